// File: doc/BRIEF.md
# Single-Slot Semaphore Mailbox

This block passes one data word at a time from a producer client to a consumer client. There is one shared value register and two boolean flags. The write-permission flag says the producer may fill the slot. The data-ready flag says the slot holds a fresh word. Flow control uses no full/empty counters. Each client steers it with two requests, both aimed at a flag of its choice. A "go" sets the flag. A "conditional wait" stalls until the flag is true, then clears the flag in the same clock edge that grants the client.

In the intended protocol the consumer first raises write permission with a go. The producer waits on that flag, writes the word and then does a go on data-ready. The consumer waits on data-ready and picks up the word. Each client drives a request that it holds until the block answers with a one-cycle grant pulse. The producer's write strobe only takes effect after that client has been granted a wait on the write-permission flag.

Top module: `sema_mailbox`

## Requirements
- R1: After reset both flags are false and the value register and the consumer read data are zero. A wait on either flag is not granted until some client does a go on that flag.
- R2: A go request (op = 1) on a flag (sel = 0 for write permission, sel = 1 for data ready) is granted at the first clock edge after the request is presented, and the flag is true after that edge.
- R3: A wait request (op = 0) on a false flag is not granted while the flag stays false. It is granted at the first clock edge at which the flag is true.
- R4: The clock edge that grants a wait also clears the flag, so a second wait on the same flag blocks until another go.
- R5: When a go and a granted wait hit the same true flag at the same edge, the wait is granted and the flag becomes true again one cycle later, so the go is not lost.
- R6: A producer write strobe takes effect only if it comes after a granted producer wait on write permission and before the next write. Each such grant allows exactly one write. Any other strobe leaves the value register unchanged.
- R7: The consumer read data shows the value register at the edge that grants the consumer a wait on data ready. A consumer wait on data ready is not granted between write permission being granted to the producer and the producer's go on data ready.
- R8: If both clients wait on the same true flag at the same edge, only the producer is granted. The consumer stays blocked.
- R9: A grant is high for exactly one cycle, even if the request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_req | input | 1 | Producer request, held until granted |
| p_op | input | 1 | Producer operation: 1 go, 0 wait |
| p_sel | input | 1 | Producer flag select: 0 write permission, 1 data ready |
| p_wr_en | input | 1 | Producer write strobe |
| p_wr_data | input | DATA_W | Producer write data |
| p_gnt | output | 1 | Producer grant pulse |
| c_req | input | 1 | Consumer request, held until granted |
| c_op | input | 1 | Consumer operation: 1 go, 0 wait |
| c_sel | input | 1 | Consumer flag select: 0 write permission, 1 data ready |
| c_gnt | output | 1 | Consumer grant pulse |
| c_rd_data | output | DATA_W | Word captured for the consumer |

## Verification
The flags cannot be read at the ports. A flag stuck true shows up as a wait that is granted one cycle after it is issued when it should have blocked. A flag that loses a set shows up as a wait that never returns. Either fault is therefore visible at the next wait on that flag. A lost or spurious write token shows up only at the consumer's next data-ready grant, as a wrong word on the read data. The tests rely on exact grant latencies and on the word captured at each data-ready grant.

// File: rtl/sema_pkg.sv
package sema_pkg;
   typedef enum logic {
      OP_WAIT = 1'b0,
      OP_GO   = 1'b1
   } sema_op_e;

   localparam int NUM_FLAGS   = 2;
   localparam int NUM_CLIENTS = 2;
   localparam int SEL_W       = 1;
   localparam int FLAG_WPERM  = 0;
   localparam int FLAG_READY  = 1;
   localparam int CL_PROD     = 0;
   localparam int CL_CONS     = 1;
endpackage

// File: rtl/sema_flag.sv
module sema_flag #(
   parameter int N_CL = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CL-1:0] set_i,
   input  logic [N_CL-1:0] take_i,
   output logic [N_CL-1:0] take_ok_o,
   output logic            flag_o
);
   if (N_CL < 1) begin : g_bad_cl
      $error("sema_flag needs at least one client");
   end

   logic flag_q, pend_q;
   logic any_set, any_take;

   // lowest client index wins the flag
   always_comb begin
      take_ok_o = '0;
      if (flag_q) begin
         for (int i = N_CL - 1; i >= 0; i--) begin
            if (take_i[i]) take_ok_o = N_CL'(1) << i;
         end
      end
   end

   assign any_set  = |set_i;
   assign any_take = |take_ok_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         flag_q <= (flag_q & ~any_take) | (any_set & ~any_take) | pend_q;
         pend_q <= any_set & any_take;
      end
   end

   assign flag_o = flag_q;

   // R4
   take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_take |=> !flag_q);
   // R2
   set_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_set && !any_take) |=> flag_q);
   // R5
   pend_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_set && any_take) |-> ##2 flag_q);
   // R8
   single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_ok_o));
endmodule

// File: rtl/sema_port.sv
module sema_port
   import sema_pkg::*;
#(
   parameter int N_FL = 2,
   parameter int SW   = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic            op_i,
   input  logic [SW-1:0]   sel_i,
   input  logic [N_FL-1:0] ok_i,
   output logic [N_FL-1:0] set_o,
   output logic [N_FL-1:0] take_o,
   output logic            gnt_o
);
   if ((1 << SW) < N_FL) begin : g_bad_sel
      $error("sema_port select too narrow for flag count");
   end

   logic gnt_q, active, win;

   assign active = req_i & ~gnt_q;

   always_comb begin
      set_o  = '0;
      take_o = '0;
      win    = 1'b0;
      if (active && int'(sel_i) < N_FL) begin
         if (op_i == OP_GO) begin
            set_o[sel_i] = 1'b1;
            win          = 1'b1;
         end else begin
            take_o[sel_i] = 1'b1;
            win           = ok_i[sel_i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q <= 1'b0;
      else        gnt_q <= win;
   end

   assign gnt_o = gnt_q;

   // R9
   gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_q |=> !gnt_q);
   // R3
   no_gnt_unasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !gnt_q);
endmodule

// File: rtl/sema_mailbox.sv
module sema_mailbox
   import sema_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit CAPTURE_RD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p_req,
   input  logic              p_op,
   input  logic              p_sel,
   input  logic              p_wr_en,
   input  logic [DATA_W-1:0] p_wr_data,
   output logic              p_gnt,
   input  logic              c_req,
   input  logic              c_op,
   input  logic              c_sel,
   output logic              c_gnt,
   output logic [DATA_W-1:0] c_rd_data
);
   if (DATA_W < 1) begin : g_bad_width
      $error("sema_mailbox DATA_W must be positive");
   end

   logic [NUM_CLIENTS-1:0]              req_v, op_v;
   logic [NUM_CLIENTS-1:0][SEL_W-1:0]   sel_v;
   logic [NUM_CLIENTS-1:0]              gnt_v;
   logic [NUM_CLIENTS-1:0][NUM_FLAGS-1:0] set_m, take_m, ok_m;
   logic [NUM_FLAGS-1:0][NUM_CLIENTS-1:0] set_t, take_t, ok_t;
   logic [NUM_FLAGS-1:0]                flag_v;

   assign req_v = {c_req, p_req};
   assign op_v  = {c_op,  p_op};
   assign sel_v = {c_sel, p_sel};

   for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_cl
      sema_port #(.N_FL(NUM_FLAGS), .SW(SEL_W)) i_port (
         .clk(clk), .rst_n(rst_n),
         .req_i(req_v[c]), .op_i(op_v[c]), .sel_i(sel_v[c]),
         .ok_i(ok_m[c]), .set_o(set_m[c]), .take_o(take_m[c]),
         .gnt_o(gnt_v[c]));
      for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_xp
         assign set_t[f][c]  = set_m[c][f];
         assign take_t[f][c] = take_m[c][f];
         assign ok_m[c][f]   = ok_t[f][c];
      end
   end

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_fl
      sema_flag #(.N_CL(NUM_CLIENTS)) i_flag (
         .clk(clk), .rst_n(rst_n),
         .set_i(set_t[f]), .take_i(take_t[f]),
         .take_ok_o(ok_t[f]), .flag_o(flag_v[f]));
   end

   assign p_gnt = gnt_v[CL_PROD];
   assign c_gnt = gnt_v[CL_CONS];

   // write token: one write per producer grant on write permission
   logic              tok_q, wr_fire;
   logic [DATA_W-1:0] value_q;
   assign wr_fire = p_wr_en & tok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tok_q   <= 1'b0;
         value_q <= '0;
      end else begin
         if (ok_m[CL_PROD][FLAG_WPERM]) tok_q <= 1'b1;
         else if (wr_fire)              tok_q <= 1'b0;
         if (wr_fire) value_q <= p_wr_data;
      end
   end

   if (CAPTURE_RD) begin : g_cap
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         rd_q <= '0;
         else if (ok_m[CL_CONS][FLAG_READY]) rd_q <= value_q;
      end
      assign c_rd_data = rd_q;
   end else begin : g_live
      assign c_rd_data = value_q;
   end

   // R6
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (p_wr_en && !tok_q) |=> value_q == $past(value_q));
   // R6
   token_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && !ok_m[CL_PROD][FLAG_WPERM]) |=> !tok_q);
   // R7
   ready_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_m[CL_CONS][FLAG_READY] |-> flag_v[FLAG_READY]);
endmodule

// File: tb/test_sema_mailbox.sv
module test_sema_mailbox;
   localparam int DW = 8;
   logic clk = 1'b0, rst_n = 1'b0;
   logic p_req = 0, p_op = 0, p_sel = 0, p_wr_en = 0;
   logic [DW-1:0] p_wr_data = '0;
   logic c_req = 0, c_op = 0, c_sel = 0;
   logic p_gnt, c_gnt;
   logic [DW-1:0] c_rd_data;
   int n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   sema_mailbox #(.DATA_W(DW)) i_sema_mailbox (
      .clk(clk), .rst_n(rst_n),
      .p_req(p_req), .p_op(p_op), .p_sel(p_sel), .p_wr_en(p_wr_en),
      .p_wr_data(p_wr_data), .p_gnt(p_gnt),
      .c_req(c_req), .c_op(c_op), .c_sel(c_sel), .c_gnt(c_gnt),
      .c_rd_data(c_rd_data));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // cl 0 producer, 1 consumer; op 1 go, 0 wait; sel 0 wperm, 1 ready
   task automatic run_op(input bit cl, input bit op, input bit sel, input int maxc,
                         output bit got, output int lat);
      @(negedge clk);
      if (cl) begin c_req = 1; c_op = op; c_sel = sel; end
      else    begin p_req = 1; p_op = op; p_sel = sel; end
      got = 0; lat = 0;
      while (!got && lat < maxc) begin
         @(posedge clk); #1;
         lat++;
         got = cl ? c_gnt : p_gnt;
      end
      @(negedge clk);
      if (cl) c_req = 0; else p_req = 0;
   endtask

   task automatic p_write(input logic [DW-1:0] d);
      @(negedge clk);
      p_wr_en = 1; p_wr_data = d;
      @(negedge clk);
      p_wr_en = 0;
   endtask

   task automatic t_reset();
      bit g; int l;
      chk(c_rd_data == 0, "R1 rd after reset", c_rd_data, 0);
      run_op(0, 0, 0, 6, g, l);
      chk(!g, "R1 wperm false after reset", g, 0);
      run_op(1, 0, 1, 6, g, l);
      chk(!g, "R1 ready false after reset", g, 0);
   endtask

   task automatic t_go_pulse();
      bit g; int l;
      @(negedge clk);
      c_req = 1; c_op = 1; c_sel = 0;
      @(posedge clk); #1;
      chk(c_gnt == 1, "R2 go granted next edge", c_gnt, 1);
      @(posedge clk); #1;
      chk(c_gnt == 0, "R9 grant one cycle with req held", c_gnt, 0);
      @(negedge clk);
      c_req = 0;
      run_op(0, 0, 0, 6, g, l);
      chk(g && l == 1, "R2 wait on set flag latency", l, 1);
      run_op(0, 0, 0, 6, g, l);
      chk(!g, "R4 flag cleared by granted wait", g, 0);
   endtask

   task automatic t_block();
      bit g, g2; int l, l2;
      fork
         run_op(0, 0, 0, 10, g, l);
         begin repeat (2) @(negedge clk); run_op(1, 1, 0, 4, g2, l2); end
      join
      chk(g && l == 4, "R3 wait released by later go", l, 4);
   endtask

   task automatic t_collide();
      bit g, g2; int l, l2;
      run_op(1, 1, 0, 4, g, l);
      fork
         run_op(0, 0, 0, 4, g, l);
         run_op(1, 1, 0, 4, g2, l2);
      join
      chk(g && l == 1, "R5 wait granted during collision", l, 1);
      run_op(0, 0, 0, 4, g, l);
      chk(g && l == 1, "R5 colliding go kept", l, 1);
      run_op(0, 0, 0, 4, g, l);
      chk(!g, "R4 flag cleared after second wait", g, 0);
   endtask

   task automatic t_priority();
      bit g, g2; int l, l2;
      run_op(0, 1, 1, 4, g, l);
      fork
         run_op(0, 0, 1, 4, g, l);
         run_op(1, 0, 1, 3, g2, l2);
      join
      chk(g && l == 1, "R8 producer wins", l, 1);
      chk(!g2, "R8 consumer blocked", g2, 0);
   endtask

   task automatic flow(input bit do_wr, input logic [DW-1:0] d,
                       input bit second, input logic [DW-1:0] d2,
                       input logic [DW-1:0] exp, input string tag);
      bit g; int l;
      run_op(1, 1, 0, 4, g, l);
      run_op(0, 0, 0, 4, g, l);
      run_op(1, 0, 1, 3, g, l);
      chk(!g, "R7 no ready before producer go", g, 0);
      if (do_wr) p_write(d);
      if (second) p_write(d2);
      run_op(0, 1, 1, 4, g, l);
      run_op(1, 0, 1, 4, g, l);
      chk(g && l == 1, "R7 ready granted after go", l, 1);
      chk(c_rd_data == exp, tag, c_rd_data, exp);
   endtask

   task automatic t_data();
      flow(1, 8'h5A, 0, 8'h00, 8'h5A, "R7 read word");
      p_write(8'hC3);
      flow(0, 8'h00, 0, 8'h00, 8'h5A, "R6 stray write ignored");
      flow(1, 8'h11, 1, 8'h22, 8'h11, "R6 one write per token");
   endtask

   initial begin
      #(8 * 20000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_go_pulse();
      t_block();
      t_collide();
      t_priority();
      t_data();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule